// File: doc/BRIEF.md
# SPI-Slave to Wishbone-Master Bridge

This block lets an external SPI master read and write a Wishbone address space. Each SPI frame, framed by an active-low chip select and clocked in mode 1 (SCLK idles low, the master launches bits on the rising edge, both sides sample on the falling edge), begins with a header. The header holds a direction bit, an optional burst bit and a word address. One or more data words follow it, most significant bit first. A write frame delivers data on MOSI. A read frame returns data on MISO in the word slot that follows the header.

All SPI inputs are brought into the system clock domain through two-flop synchronizers, and SCLK edges are detected there, so the system clock must run at least four times faster than SCLK. The Wishbone side issues one classic single cycle per data word. STB and CYC are held until ACK, and all byte selects are set. With burst enabled, words keep streaming at consecutive addresses until chip select rises. On the read side, the next word is fetched while the current one shifts out.

The frame state machine has five states. FR_IDLE waits for chip select. FR_HDR collects header bits. FR_WDATA collects write words. FR_RDATA shifts read words out. FR_DONE ignores further clocks. Its transitions are:
- FR_IDLE→FR_HDR when chip select falls.
- FR_HDR→FR_WDATA or FR_HDR→FR_RDATA on the last header bit, chosen by the direction bit.
- FR_WDATA→FR_DONE or FR_RDATA→FR_DONE at the end of the word in a single frame.
- Any state→FR_IDLE when chip select is high.

The Wishbone master has two states, WB_IDLE and WB_BUSY. It moves WB_IDLE→WB_BUSY on a request and WB_BUSY→WB_IDLE on ACK.

Top module: `spiwb_bridge`

## Requirements
- R1: After reset and while chip select is high, wb_cyc_o and wb_stb_o are 0 and spi_miso is 0.
- R2: With the default parameters (16-bit data, 16-bit header, burst enabled), header bit 15 is the direction (1 = write), bit 14 is the burst flag and bits 13..0 are the word address, sent MSB first. A single write frame produces exactly one Wishbone write carrying that address and the following 16-bit MOSI word, with wb_sel_o all ones.
- R3: A single read frame produces one Wishbone read of the header address. The returned wb_dat_i appears on spi_miso MSB first, one bit per SCLK rising edge, in the 16-bit slot after the header.
- R4: Once wb_stb_o is raised, wb_stb_o and wb_cyc_o stay high and wb_adr_o, wb_we_o and wb_dat_o stay unchanged until the cycle in which wb_ack_i is high. They drop in the cycle after that.
- R5: A burst write frame (burst flag 1) writes each received word to the header address plus the word index. The 14-bit address wraps modulo 2^14.
- R6: A burst read frame returns on spi_miso the data of the header address plus the word index, for every word slot clocked before chip select rises.
- R7: Raising chip select mid-frame discards the partial frame. No Wishbone write is made for an incomplete word, and the next frame is decoded from a fresh header.
- R8: spi_miso is 0 during the header, during every write frame and whenever chip select is high.
- R9: In a single (non-burst) frame, SCLK cycles after the first data word cause no further Wishbone cycle, and spi_miso stays 0 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| wb_adr_o | output | ADDR_W | Wishbone word address |
| wb_dat_o | output | DATA_W | Wishbone write data |
| wb_dat_i | input | DATA_W | Wishbone read data |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | DATA_W/8 | Wishbone byte selects |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
Every SCLK edge reaches the frame logic three system cycles after the bench drives it: two synchronizer stages plus the edge register. A Wishbone request then follows one cycle after the last header bit (reads) or the last data bit (writes), and the acknowledge comes zero to three cycles later. The bench holds each SCLK level for ten system cycles. It reads spi_miso just before it drives the falling edge, seven cycles after the bridge has updated the line. It inspects its log of Wishbone transactions only after chip select has been high for sixty cycles, when every cycle has long completed. The hold rules of R4 are watched on every clock by a bench monitor, while the random acknowledge latency forces wait states.

// File: rtl/spiwb_pkg.sv
package spiwb_pkg;

    // frame sequencer states
    typedef enum logic [2:0] {
        FR_IDLE  = 3'd0,
        FR_HDR   = 3'd1,
        FR_WDATA = 3'd2,
        FR_RDATA = 3'd3,
        FR_DONE  = 3'd4
    } frame_st_t;

    // bus master states
    typedef enum logic {
        WB_IDLE = 1'b0,
        WB_BUSY = 1'b1
    } wb_st_t;

endpackage

// File: rtl/spiwb_sync.sv
module spiwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);

    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] mosi_q;
    logic              sclk_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_q <= '0;
                    cs_q   <= '1;
                    mosi_q <= '0;
                end else begin
                    sclk_q <= sclk_i;
                    cs_q   <= cs_n_i;
                    mosi_q <= mosi_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_q <= '0;
                    cs_q   <= '1;
                    mosi_q <= '0;
                end else begin
                    sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
                    cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
                    mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_q[STAGES-1];
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
    assign cs_act    = ~cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];

endmodule

// File: rtl/spiwb_wbm.sv
module spiwb_wbm
    import spiwb_pkg::*;
#(
    parameter int AW = 14,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_adr,
    input  logic [DW-1:0] req_dat,
    input  logic          wb_ack,
    input  logic [DW-1:0] wb_dat_i,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic          wb_we,
    output logic [AW-1:0] wb_adr,
    output logic [DW-1:0] wb_dat_o,
    output logic [DW/8-1:0] wb_sel,
    output logic [DW-1:0] rd_data
);

    wb_st_t        st_q;
    wb_st_t        st_nxt;
    logic          we_q;
    logic [AW-1:0] adr_q;
    logic [DW-1:0] dat_q;
    logic [DW-1:0] rd_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= WB_IDLE;
        else     st_q <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            WB_IDLE: if (req)    st_nxt = WB_BUSY;
            WB_BUSY: if (wb_ack) st_nxt = WB_IDLE;
            default:             st_nxt = WB_IDLE;
        endcase
    end

    // request capture and read data latch
    always_ff @(posedge clk) begin
        if (rst) begin
            we_q  <= 1'b0;
            adr_q <= '0;
            dat_q <= '0;
            rd_q  <= '0;
        end else begin
            if (st_q == WB_IDLE && req) begin
                we_q  <= req_we;
                adr_q <= req_adr;
                dat_q <= req_dat;
            end
            if (st_q == WB_BUSY && wb_ack && !we_q) begin
                rd_q <= wb_dat_i;
            end
        end
    end

    // outputs
    always_comb begin
        wb_cyc = 1'b0;
        wb_stb = 1'b0;
        unique case (st_q)
            WB_IDLE: ;
            WB_BUSY: begin
                wb_cyc = 1'b1;
                wb_stb = 1'b1;
            end
            default: ;
        endcase
    end

    assign wb_we    = we_q;
    assign wb_adr   = adr_q;
    assign wb_dat_o = dat_q;
    assign wb_sel   = '1;
    assign rd_data  = rd_q;

endmodule

// File: rtl/spiwb_frame.sv
module spiwb_frame
    import spiwb_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 14,
    parameter int HDR_BITS = 16,
    parameter bit BURST_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          fall,
    input  logic          cs_act,
    input  logic          mosi,
    input  logic [DW-1:0] rd_data,
    output logic          req,
    output logic          req_we,
    output logic [AW-1:0] req_adr,
    output logic [DW-1:0] req_dat,
    output logic          miso
);

    localparam int MAXB  = (HDR_BITS > DW) ? HDR_BITS : DW;
    localparam int CNT_W = $clog2(MAXB);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DW - 1);

    frame_st_t         st_q;
    frame_st_t         st_nxt;
    logic [CNT_W-1:0]  bcnt;
    logic [HDR_BITS-2:0] hdr_sh;
    logic [DW-2:0]     wr_sh;
    logic [DW-1:0]     rd_sh;
    logic              miso_q;
    logic [AW-1:0]     addr;
    logic              burst_q;

    logic [HDR_BITS-1:0] hdr_full;
    logic              hdr_dir;
    logic              hdr_burst;
    logic [AW-1:0]     hdr_adr;
    logic [DW-1:0]     wr_word;
    logic [AW-1:0]     addr_inc;

    assign hdr_full  = {hdr_sh, mosi};
    assign hdr_dir   = hdr_full[HDR_BITS-1];
    assign hdr_burst = BURST_EN && hdr_full[HDR_BITS-2];
    assign hdr_adr   = hdr_full[AW-1:0];
    assign wr_word   = {wr_sh, mosi};
    assign addr_inc  = addr + AW'(1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= FR_IDLE;
        else     st_q <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            FR_IDLE:  if (cs_act) st_nxt = FR_HDR;
            FR_HDR:   if (fall && bcnt == HDR_LAST)
                          st_nxt = hdr_dir ? FR_WDATA : FR_RDATA;
            FR_WDATA: if (fall && bcnt == WORD_LAST && !burst_q)
                          st_nxt = FR_DONE;
            FR_RDATA: if (fall && bcnt == WORD_LAST && !burst_q)
                          st_nxt = FR_DONE;
            FR_DONE:  st_nxt = FR_DONE;
            default:  st_nxt = FR_IDLE;
        endcase
        if (!cs_act) st_nxt = FR_IDLE;
    end

    // datapath: counters, shifters, requests
    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt    <= '0;
            hdr_sh  <= '0;
            wr_sh   <= '0;
            rd_sh   <= '0;
            miso_q  <= 1'b0;
            addr    <= '0;
            burst_q <= 1'b0;
            req     <= 1'b0;
            req_we  <= 1'b0;
            req_adr <= '0;
            req_dat <= '0;
        end else if (!cs_act) begin
            bcnt    <= '0;
            miso_q  <= 1'b0;
            burst_q <= 1'b0;
            req     <= 1'b0;
        end else begin
            req <= 1'b0;
            case (st_q)
                FR_HDR: begin
                    if (fall) begin
                        hdr_sh <= hdr_full[HDR_BITS-2:0];
                        if (bcnt == HDR_LAST) begin
                            bcnt    <= '0;
                            addr    <= hdr_adr;
                            burst_q <= hdr_burst;
                            if (!hdr_dir) begin
                                req     <= 1'b1;
                                req_we  <= 1'b0;
                                req_adr <= hdr_adr;
                            end
                        end else begin
                            bcnt <= bcnt + CNT_W'(1);
                        end
                    end
                end
                FR_WDATA: begin
                    if (fall) begin
                        wr_sh <= wr_word[DW-2:0];
                        if (bcnt == WORD_LAST) begin
                            bcnt    <= '0;
                            req     <= 1'b1;
                            req_we  <= 1'b1;
                            req_adr <= addr;
                            req_dat <= wr_word;
                            addr    <= addr_inc;
                        end else begin
                            bcnt <= bcnt + CNT_W'(1);
                        end
                    end
                end
                FR_RDATA: begin
                    if (rise) begin
                        if (bcnt == '0) begin
                            miso_q <= rd_data[DW-1];
                            rd_sh  <= {rd_data[DW-2:0], 1'b0};
                            if (burst_q) begin
                                addr    <= addr_inc;
                                req     <= 1'b1;
                                req_we  <= 1'b0;
                                req_adr <= addr_inc;
                            end
                        end else begin
                            miso_q <= rd_sh[DW-1];
                            rd_sh  <= {rd_sh[DW-2:0], 1'b0};
                        end
                    end
                    if (fall) begin
                        if (bcnt == WORD_LAST) bcnt <= '0;
                        else                   bcnt <= bcnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // output
    always_comb begin
        miso = 1'b0;
        unique case (st_q)
            FR_RDATA: miso = miso_q;
            default:  miso = 1'b0;
        endcase
    end

endmodule

// File: rtl/spiwb_bridge.sv
module spiwb_bridge #(
    parameter int DATA_W   = 16,
    parameter bit EXT_ADDR = 1'b1,
    parameter bit BURST_EN = 1'b1,
    parameter int SYNC_STG = 2,
    localparam int HDR_BITS = EXT_ADDR ? 16 : 8,
    localparam int ADDR_W   = HDR_BITS - 1 - (BURST_EN ? 1 : 0),
    localparam int SEL_W    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic              wb_we_o,
    output logic [SEL_W-1:0]  wb_sel_o,
    output logic              wb_stb_o,
    output logic              wb_cyc_o,
    input  logic              wb_ack_i
);

    logic              rise;
    logic              fall;
    logic              cs_act;
    logic              mosi_s;
    logic              req;
    logic              req_we;
    logic [ADDR_W-1:0] req_adr;
    logic [DATA_W-1:0] req_dat;
    logic [DATA_W-1:0] rd_data;

    spiwb_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sclk_rise (rise),
        .sclk_fall (fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spiwb_frame #(
        .DW       (DATA_W),
        .AW       (ADDR_W),
        .HDR_BITS (HDR_BITS),
        .BURST_EN (BURST_EN)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .fall    (fall),
        .cs_act  (cs_act),
        .mosi    (mosi_s),
        .rd_data (rd_data),
        .req     (req),
        .req_we  (req_we),
        .req_adr (req_adr),
        .req_dat (req_dat),
        .miso    (spi_miso)
    );

    spiwb_wbm #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_wbm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_we   (req_we),
        .req_adr  (req_adr),
        .req_dat  (req_dat),
        .wb_ack   (wb_ack_i),
        .wb_dat_i (wb_dat_i),
        .wb_cyc   (wb_cyc_o),
        .wb_stb   (wb_stb_o),
        .wb_we    (wb_we_o),
        .wb_adr   (wb_adr_o),
        .wb_dat_o (wb_dat_o),
        .wb_sel   (wb_sel_o),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/spiwb_bridge_chk.sv
module spiwb_bridge_chk #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic              wb_we_o,
    input logic              wb_stb_o,
    input logic              wb_cyc_o,
    input logic              wb_ack_i
);

    // R4
    stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && wb_cyc_o));

    // R4
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb_o && !wb_ack_i) |=>
            ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb_o && wb_ack_i) |=> !wb_stb_o);

    // R8
    miso_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
            |-> !spi_miso);

    // R8
    miso_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb_o && wb_we_o) |-> !spi_miso);

endmodule

bind spiwb_bridge spiwb_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_we_o  (wb_we_o),
    .wb_stb_o (wb_stb_o),
    .wb_cyc_o (wb_cyc_o),
    .wb_ack_i (wb_ack_i)
);

// File: tb/test_spiwb_bridge.sv
`timescale 1ns/1ps
module test_spiwb_bridge;

    localparam int H = 10;   // system cycles per SCLK half period

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [13:0] wb_adr;
    logic [15:0] wb_dat_o;
    logic [15:0] wb_dat_i = '0;
    logic        wb_we;
    logic [1:0]  wb_sel;
    logic        wb_stb;
    logic        wb_cyc;
    logic        wb_ack = 1'b0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    spiwb_bridge i_spiwb_bridge (
        .clk      (clk),
        .rst      (rst),
        .spi_sclk (sclk),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .wb_adr_o (wb_adr),
        .wb_dat_o (wb_dat_o),
        .wb_dat_i (wb_dat_i),
        .wb_we_o  (wb_we),
        .wb_sel_o (wb_sel),
        .wb_stb_o (wb_stb),
        .wb_cyc_o (wb_cyc),
        .wb_ack_i (wb_ack)
    );

    function automatic logic [15:0] rdval(input logic [13:0] a);
        logic [15:0] p;
        p = 16'(a) * 16'd40503;
        return p ^ 16'h5A3C;
    endfunction

    // ---------------- bus slave model and logs ----------------
    logic [13:0] wlog_adr [0:7];
    logic [15:0] wlog_dat [0:7];
    logic [1:0]  wlog_sel [0:7];
    logic [13:0] rlog_adr [0:7];
    int wcnt = 0;
    int rcnt = 0;
    int lat  = 0;

    always @(posedge clk) begin
        if (wb_ack) begin
            wb_ack <= 1'b0;
            lat    <= $urandom_range(0, 3);
        end else if (wb_cyc && wb_stb) begin
            if (lat == 0) begin
                wb_ack <= 1'b1;
                if (wb_we) begin
                    if (wcnt < 8) begin
                        wlog_adr[wcnt] <= wb_adr;
                        wlog_dat[wcnt] <= wb_dat_o;
                        wlog_sel[wcnt] <= wb_sel;
                    end
                    wcnt <= wcnt + 1;
                end else begin
                    wb_dat_i <= rdval(wb_adr);
                    if (rcnt < 8) rlog_adr[rcnt] <= wb_adr;
                    rcnt <= rcnt + 1;
                end
            end else begin
                lat <= lat - 1;
            end
        end
    end

    // R4 monitor: held request must not change or drop before ACK
    int   hold_viol = 0;
    logic prev_wait = 1'b0;
    logic [13:0] prev_adr;
    logic [15:0] prev_dat;
    logic        prev_we;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_wait && (!wb_stb || !wb_cyc || wb_adr !== prev_adr ||
                              wb_dat_o !== prev_dat || wb_we !== prev_we))
                hold_viol = hold_viol + 1;
            prev_wait = wb_stb && !wb_ack;
            prev_adr  = wb_adr;
            prev_dat  = wb_dat_o;
            prev_we   = wb_we;
        end
    end

    // ---------------- check helper ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- SPI master ----------------
    logic [15:0] tx_words [0:3];
    logic [15:0] rx_words [0:3];
    logic        hdr_miso;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic r);
        @(negedge clk);
        mosi = b;
        sclk = 1'b1;
        wait_clk(H);
        r = miso;        // master samples on the falling edge
        sclk = 1'b0;
        wait_clk(H);
    endtask

    task automatic clear_logs();
        @(negedge clk);
        wcnt = 0;
        rcnt = 0;
    endtask

    task automatic spi_frame(input logic dir, input logic brst,
                             input logic [13:0] a, input int nw);
        logic [15:0] hdr;
        logic        r;
        logic [15:0] word;
        hdr = {dir, brst, a};
        hdr_miso = 1'b0;
        clear_logs();
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 15; i >= 0; i--) begin
            spi_bit(hdr[i], r);
            hdr_miso = hdr_miso | r;
        end
        for (int w = 0; w < nw; w++) begin
            for (int i = 15; i >= 0; i--) begin
                spi_bit(tx_words[w][i], r);
                word[i] = r;
            end
            rx_words[w] = word;
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(6 * H);
    endtask

    task automatic spi_partial(input logic [15:0] hdr, input int nbits);
        logic [31:0] bits;
        logic        r;
        bits = {hdr, tx_words[0]};
        clear_logs();
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 31; i > 31 - nbits; i--) spi_bit(bits[i], r);
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(6 * H);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait_clk(150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic        dir;
        logic        brst;
        logic [13:0] a;
        int          nw;
        void'($urandom(32'd20240611));

        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        // R1: reset state
        chk("R1 cyc", {31'd0, wb_cyc}, 32'd0);
        chk("R1 stb", {31'd0, wb_stb}, 32'd0);
        chk("R1 miso", {31'd0, miso}, 32'd0);

        // R2, R9: single write with an extra trailing word
        tx_words[0] = 16'hCAFE;
        tx_words[1] = 16'h1234;
        spi_frame(1'b1, 1'b0, 14'h0002, 2);
        chk("R9 single write count", wcnt, 1);
        chk("R2 write adr", {18'd0, wlog_adr[0]}, 32'h0002);
        chk("R2 write dat", {16'd0, wlog_dat[0]}, 32'hCAFE);
        chk("R2 write sel", {30'd0, wlog_sel[0]}, 32'h3);
        chk("R8 write frame miso", {31'd0, hdr_miso | (|rx_words[0]) | (|rx_words[1])}, 32'd0);

        // R3, R9: single read with an extra trailing slot
        spi_frame(1'b0, 1'b0, 14'h0010, 2);
        chk("R3 read data", {16'd0, rx_words[0]}, {16'd0, rdval(14'h0010)});
        chk("R3 read count", rcnt, 1);
        chk("R3 read adr", {18'd0, rlog_adr[0]}, 32'h0010);
        chk("R8 header miso", {31'd0, hdr_miso}, 32'd0);
        chk("R9 trailing slot miso", {16'd0, rx_words[1]}, 32'd0);

        // R5: burst write wrapping the address space
        tx_words[0] = 16'h1111; tx_words[1] = 16'h2222;
        tx_words[2] = 16'h3333; tx_words[3] = 16'h4444;
        spi_frame(1'b1, 1'b1, 14'h3FFE, 4);
        chk("R5 burst count", wcnt, 4);
        for (int w = 0; w < 4; w++) begin
            chk("R5 burst adr", {18'd0, wlog_adr[w]}, {18'd0, 14'(14'h3FFE + w)});
            chk("R5 burst dat", {16'd0, wlog_dat[w]}, {16'd0, tx_words[w]});
        end

        // R6: burst read
        spi_frame(1'b0, 1'b1, 14'h0100, 3);
        for (int w = 0; w < 3; w++) begin
            chk("R6 burst read data", {16'd0, rx_words[w]}, {16'd0, rdval(14'(14'h0100 + w))});
            chk("R6 burst read adr", {18'd0, rlog_adr[w]}, {18'd0, 14'(14'h0100 + w)});
        end

        // R7: abort during the data word of a write
        tx_words[0] = 16'hBEEF;
        spi_partial({1'b1, 1'b0, 14'h0055}, 16 + 9);
        chk("R7 partial write", wcnt, 0);
        // R7: abort during the header, then a clean read
        spi_partial({1'b1, 1'b0, 14'h3000}, 5);
        chk("R7 header abort", wcnt + rcnt, 0);
        spi_frame(1'b0, 1'b0, 14'h0ABC, 1);
        chk("R7 fresh header read", {16'd0, rx_words[0]}, {16'd0, rdval(14'h0ABC)});
        tx_words[0] = 16'h5599;
        spi_frame(1'b1, 1'b0, 14'h0033, 1);
        chk("R7 fresh header write adr", {18'd0, wlog_adr[0]}, 32'h0033);
        chk("R7 fresh header write dat", {16'd0, wlog_dat[0]}, 32'h5599);

        // random frames
        for (int k = 0; k < 20; k++) begin
            dir  = 1'($urandom);
            brst = 1'($urandom);
            a    = 14'($urandom);
            nw   = brst ? int'($urandom_range(1, 3)) : 1;
            for (int w = 0; w < 4; w++) tx_words[w] = 16'($urandom);
            spi_frame(dir, brst, a, nw);
            chk("R8 random header miso", {31'd0, hdr_miso}, 32'd0);
            if (dir) begin
                chk(brst ? "R5 random write count" : "R2 random write count", wcnt, nw);
                for (int w = 0; w < nw; w++) begin
                    chk("R5 random write adr", {18'd0, wlog_adr[w]}, {18'd0, 14'(a + w)});
                    chk("R2 random write dat", {16'd0, wlog_dat[w]}, {16'd0, tx_words[w]});
                end
            end else begin
                if (!brst) chk("R3 random read count", rcnt, 1);
                for (int w = 0; w < nw; w++)
                    chk(brst ? "R6 random read data" : "R3 random read data",
                        {16'd0, rx_words[w]}, {16'd0, rdval(14'(a + w))});
            end
        end

        // R4: request held and stable through wait states
        chk("R4 hold violations", hold_viol, 0);
        // R1: idle again after all traffic
        chk("R1 idle stb", {31'd0, wb_stb}, 32'd0);
        chk("R1 idle miso", {31'd0, miso}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule